// File: doc/BRIEF.md
# Read-Only Victim Line Buffer

This block sits beside a last-level cache and keeps a small, fully associative set of lines that the cache has just evicted and that belong to read-only data. Such lines are always clean, so holding them costs no writeback. When the cache later misses on one of them, it can fetch the line from this buffer instead of issuing another memory read. Entries are replaced in first-in first-out order.

Each eviction arrives on the victim port with its line address, full line data, a read-only tag and a per-sector dirty mask. A clean read-only victim is kept. A victim with any dirty sector is never kept: its dirty sectors leave through the writeback port one cycle later. A clean victim without the read-only tag is simply dropped. Lookups from the cache's miss path search all entries at once. The answer comes back one cycle later, and a hit removes the entry, because the line returns to the cache.

Top module: `ro_victim_buf`

## Requirements
- R1: After reset the buffer holds no entries, and both `rsp_valid` and `wb_valid` are low.
- R2: A victim with `vic_ro`=1 and `vic_dirty`=0 is stored. A later lookup of its address gives `rsp_valid`=1, `rsp_hit`=1 and the stored line on `rsp_data` one cycle after `lk_valid`.
- R3: A lookup hit invalidates that entry, so a second lookup of the same address misses.
- R4: A lookup that matches no valid entry gives `rsp_valid`=1, `rsp_hit`=0 and `rsp_data` all zeros one cycle later.
- R5: Replacement is first-in first-out over ENTRIES slots, and the write pointer wraps. After ENTRIES+k distinct inserts, only the last ENTRIES addresses can hit.
- R6: Storing an address that is already held overwrites that entry with the new data. It does not use a new slot and does not advance the FIFO order.
- R7: A victim with any bit of `vic_dirty` set is never stored, even when `vic_ro`=1. One cycle later `wb_valid`=1, with `wb_mask` equal to the victim's dirty mask and `wb_addr`/`wb_data` equal to the victim's address and line. Bit s of the mask covers bits [s*SECTOR_BITS +: SECTOR_BITS] of the line.
- R8: A clean victim with `vic_ro`=0 is neither stored nor written back (`wb_valid` stays 0).
- R9: A dirty victim whose address is currently held invalidates that entry, so no stale copy can hit.
- R10: A lookup searches the contents as they were before any insert in the same cycle. A lookup and an insert of the same address in one cycle therefore give a miss, and the next lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vic_valid | input | 1 | Eviction present this cycle |
| vic_addr | input | ADDR_W | Line address of the victim |
| vic_data | input | SECTORS*SECTOR_BITS | Victim line data |
| vic_ro | input | 1 | Victim belongs to read-only data |
| vic_dirty | input | SECTORS | Per-sector dirty mask of the victim |
| lk_valid | input | 1 | Miss lookup present this cycle |
| lk_addr | input | ADDR_W | Line address looked up |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Lookup found the line |
| rsp_data | output | SECTORS*SECTOR_BITS | Line returned on hit, zero on miss |
| wb_valid | output | 1 | Writeback of dirty sectors present |
| wb_addr | output | ADDR_W | Writeback line address |
| wb_data | output | SECTORS*SECTOR_BITS | Writeback line data |
| wb_mask | output | SECTORS | Sectors to be written back |

## Verification
If the valid bits are wrong, a lookup shows it in the very next response: a removed line that still hits, or a kept line that misses. A wrong write pointer or a duplicated slot takes longer to see. It appears only once the buffer wraps, when the wrong address survives or a re-stored address pushes out an extra older line, so the checks fill the buffer past its depth before sweeping every address. A fault in how victims are sorted shows at the writeback port one cycle after the eviction, as a wrong valid or mask.

// File: rtl/rovb_pkg.sv
package rovb_pkg;

    localparam int DEF_ENTRIES     = 8;
    localparam int DEF_SECTORS     = 4;
    localparam int DEF_SECTOR_BITS = 256;
    localparam int DEF_ADDR_W      = 26;

    // What happens to an evicted line
    typedef enum logic [1:0] {
        DISP_DROP      = 2'd0,
        DISP_KEEP      = 2'd1,
        DISP_WRITEBACK = 2'd2
    } disp_e;

    // Any dirty sector forces writeback and bars the line from the buffer
    function automatic disp_e classify(input logic valid, input logic ro, input logic dirty_any);
        disp_e d;
        if (!valid)
            d = DISP_DROP;
        else if (dirty_any)
            d = DISP_WRITEBACK;
        else if (ro)
            d = DISP_KEEP;
        else
            d = DISP_DROP;
        return d;
    endfunction

endpackage

// File: rtl/rovb_match.sv
module rovb_match #(
    parameter int ENTRIES = rovb_pkg::DEF_ENTRIES,
    parameter int ADDR_W  = rovb_pkg::DEF_ADDR_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]             ent_valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             match,
    output logic                           any,
    output logic [IDX_W-1:0]               idx
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = ent_valid[i] && (ent_addr[i] == key);
    end

    assign any = |match;

    // Encoder; at most one bit is set because addresses are unique
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

endmodule

// File: rtl/rovb_store.sv
module rovb_store #(
    parameter int ENTRIES = rovb_pkg::DEF_ENTRIES,
    parameter int ADDR_W  = rovb_pkg::DEF_ADDR_W,
    parameter int LINE_W  = rovb_pkg::DEF_SECTORS * rovb_pkg::DEF_SECTOR_BITS,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ins_en,
    input  logic [ADDR_W-1:0]              ins_addr,
    input  logic [LINE_W-1:0]              ins_data,
    input  logic                           vic_kill,
    input  logic [ENTRIES-1:0]             vic_match,
    input  logic                           vic_any,
    input  logic [IDX_W-1:0]               vic_idx,
    input  logic                           lk_fire,
    input  logic [ENTRIES-1:0]             lk_match,
    output logic [ENTRIES-1:0]             ent_valid,
    output logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr,
    output logic [ENTRIES-1:0][LINE_W-1:0] ent_data
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] wr_ptr;
    logic [IDX_W-1:0] tgt;
    logic             advance;

    // Re-storing a held address reuses its slot in place
    assign tgt     = vic_any ? vic_idx : wr_ptr;
    assign advance = ins_en && !vic_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            wr_ptr    <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if ((lk_fire && lk_match[i]) || (vic_kill && vic_match[i]))
                    ent_valid[i] <= 1'b0;
            end
            if (ins_en)
                ent_valid[tgt] <= 1'b1;
            if (advance)
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            ent_addr[tgt] <= ins_addr;
            ent_data[tgt] <= ins_data;
        end
    end

endmodule

// File: rtl/rovb_wb.sv
module rovb_wb #(
    parameter int ADDR_W  = rovb_pkg::DEF_ADDR_W,
    parameter int SECTORS = rovb_pkg::DEF_SECTORS,
    parameter int LINE_W  = rovb_pkg::DEF_SECTORS * rovb_pkg::DEF_SECTOR_BITS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic [LINE_W-1:0]  data_in,
    input  logic [SECTORS-1:0] mask_in,
    output logic               wb_valid,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [LINE_W-1:0]  wb_data,
    output logic [SECTORS-1:0] wb_mask
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_mask  <= '0;
        end else begin
            wb_valid <= fire;
            wb_mask  <= fire ? mask_in : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (fire) begin
            wb_addr <= addr_in;
            wb_data <= data_in;
        end
    end

endmodule

// File: rtl/ro_victim_buf.sv
module ro_victim_buf
    import rovb_pkg::*;
#(
    parameter int ENTRIES     = DEF_ENTRIES,
    parameter int SECTORS     = DEF_SECTORS,
    parameter int SECTOR_BITS = DEF_SECTOR_BITS,
    parameter int ADDR_W      = DEF_ADDR_W,
    localparam int LINE_W     = SECTORS * SECTOR_BITS,
    localparam int IDX_W      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               vic_valid,
    input  logic [ADDR_W-1:0]  vic_addr,
    input  logic [LINE_W-1:0]  vic_data,
    input  logic               vic_ro,
    input  logic [SECTORS-1:0] vic_dirty,
    input  logic               lk_valid,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [LINE_W-1:0]  rsp_data,
    output logic               wb_valid,
    output logic [ADDR_W-1:0]  wb_addr,
    output logic [LINE_W-1:0]  wb_data,
    output logic [SECTORS-1:0] wb_mask
);

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr;
    logic [ENTRIES-1:0][LINE_W-1:0] ent_data;

    logic [ENTRIES-1:0] vic_match;
    logic               vic_any;
    logic [IDX_W-1:0]   vic_idx;
    logic [ENTRIES-1:0] lk_match;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;

    disp_e disp;
    logic  ins_en;
    logic  wb_fire;

    assign disp    = classify(vic_valid, vic_ro, |vic_dirty);
    assign ins_en  = (disp == DISP_KEEP);
    assign wb_fire = (disp == DISP_WRITEBACK);

    rovb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) vic_match_i (
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .key       (vic_addr),
        .match     (vic_match),
        .any       (vic_any),
        .idx       (vic_idx)
    );

    rovb_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) lk_match_i (
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .key       (lk_addr),
        .match     (lk_match),
        .any       (lk_any),
        .idx       (lk_idx)
    );

    rovb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) store_i (
        .clk       (clk),
        .rst       (rst),
        .ins_en    (ins_en),
        .ins_addr  (vic_addr),
        .ins_data  (vic_data),
        .vic_kill  (wb_fire),
        .vic_match (vic_match),
        .vic_any   (vic_any),
        .vic_idx   (vic_idx),
        .lk_fire   (lk_valid),
        .lk_match  (lk_match),
        .ent_valid (ent_valid),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    rovb_wb #(.ADDR_W(ADDR_W), .SECTORS(SECTORS), .LINE_W(LINE_W)) wb_i (
        .clk      (clk),
        .rst      (rst),
        .fire     (wb_fire),
        .addr_in  (vic_addr),
        .data_in  (vic_data),
        .mask_in  (vic_dirty),
        .wb_valid (wb_valid),
        .wb_addr  (wb_addr),
        .wb_data  (wb_data),
        .wb_mask  (wb_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_any;
            rsp_data  <= (lk_valid && lk_any) ? ent_data[lk_idx] : '0;
        end
    end

endmodule

// File: rtl/ro_victim_buf_chk.sv
module ro_victim_buf_chk #(
    parameter int ENTRIES = 8,
    parameter int SECTORS = 4,
    parameter int LINE_W  = 1024
) (
    input logic               clk,
    input logic               rst,
    input logic               vic_valid,
    input logic               vic_ro,
    input logic [SECTORS-1:0] vic_dirty,
    input logic               lk_valid,
    input logic [ENTRIES-1:0] lk_match,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [LINE_W-1:0]  rsp_data,
    input logic               wb_valid,
    input logic [SECTORS-1:0] wb_mask
);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (!rsp_valid && !wb_valid));

    // R2
    rsp_follows_lookup_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (rsp_valid == $past(lk_valid)));

    // R4
    miss_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_data == '0));

    // R7
    wb_from_dirty_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> ($past(vic_valid) && ($past(vic_dirty) != '0) && (wb_mask == $past(vic_dirty))));

    // R8
    clean_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (vic_valid && vic_dirty == '0) |=> !wb_valid);

    // R6
    unique_addr_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> $onehot0(lk_match));

endmodule

bind ro_victim_buf ro_victim_buf_chk #(
    .ENTRIES (ENTRIES),
    .SECTORS (SECTORS),
    .LINE_W  (LINE_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .vic_valid (vic_valid),
    .vic_ro    (vic_ro),
    .vic_dirty (vic_dirty),
    .lk_valid  (lk_valid),
    .lk_match  (lk_match),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_data  (rsp_data),
    .wb_valid  (wb_valid),
    .wb_mask   (wb_mask)
);

// File: tb/ro_victim_buf_tb_top.sv
module ro_victim_buf_tb_top;

    localparam int ENTRIES     = 8;
    localparam int SECTORS     = 4;
    localparam int SECTOR_BITS = 256;
    localparam int ADDR_W      = 26;
    localparam int LINE_W      = SECTORS * SECTOR_BITS;
    localparam int WORDS       = LINE_W / 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               vic_valid = 1'b0;
    logic [ADDR_W-1:0]  vic_addr = '0;
    logic [LINE_W-1:0]  vic_data = '0;
    logic               vic_ro = 1'b0;
    logic [SECTORS-1:0] vic_dirty = '0;
    logic               lk_valid = 1'b0;
    logic [ADDR_W-1:0]  lk_addr = '0;
    logic               rsp_valid, rsp_hit, wb_valid;
    logic [LINE_W-1:0]  rsp_data, wb_data;
    logic [ADDR_W-1:0]  wb_addr;
    logic [SECTORS-1:0] wb_mask;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ro_victim_buf #(
        .ENTRIES(ENTRIES), .SECTORS(SECTORS), .SECTOR_BITS(SECTOR_BITS), .ADDR_W(ADDR_W)
    ) dut_i (
        .clk(clk), .rst(rst),
        .vic_valid(vic_valid), .vic_addr(vic_addr), .vic_data(vic_data),
        .vic_ro(vic_ro), .vic_dirty(vic_dirty),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data), .wb_mask(wb_mask)
    );

    function automatic logic [LINE_W-1:0] pat(input int a, input int salt);
        logic [LINE_W-1:0] r;
        for (int w = 0; w < WORDS; w++)
            r[w*32 +: 32] = 32'(a) * 32'h0100_0193 + 32'(w * 7) + 32'(salt) * 32'h9E37;
        return r;
    endfunction

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    // Called at a falling edge; returns at the next falling edge with outputs settled
    task automatic push(input int a, input int salt, input logic ro, input logic [SECTORS-1:0] dirty);
        vic_valid = 1'b1; vic_addr = ADDR_W'(a); vic_data = pat(a, salt);
        vic_ro = ro; vic_dirty = dirty;
        @(negedge clk);
        vic_valid = 1'b0; vic_ro = 1'b0; vic_dirty = '0;
    endtask

    task automatic lookup(input int a, input logic exp_hit, input int salt, input string req);
        logic [LINE_W-1:0] exp_d;
        lk_valid = 1'b1; lk_addr = ADDR_W'(a);
        @(negedge clk);
        lk_valid = 1'b0;
        exp_d = exp_hit ? pat(a, salt) : '0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== exp_hit || rsp_data !== exp_d) begin
            fails++;
            $display("FAIL %s addr=%0h: valid=%b hit=%b data[31:0]=%h, expected valid=1 hit=%b data[31:0]=%h",
                     req, a, rsp_valid, rsp_hit, rsp_data[31:0], exp_hit, exp_d[31:0]);
        end
    endtask

    task automatic chk_wb(input logic ev, input int a, input int salt, input logic [SECTORS-1:0] m, input string req);
        checks++;
        if (ev) begin
            if (wb_valid !== 1'b1 || wb_mask !== m || wb_addr !== ADDR_W'(a) || wb_data !== pat(a, salt)) begin
                fails++;
                $display("FAIL %s: wb_valid=%b mask=%b addr=%h, expected 1 mask=%b addr=%h",
                         req, wb_valid, wb_mask, wb_addr, m, ADDR_W'(a));
            end
        end else if (wb_valid !== 1'b0) begin
            fails++;
            $display("FAIL %s: wb_valid=%b, expected 0", req, wb_valid);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: idle outputs, nothing held
        checks++;
        if (rsp_valid !== 1'b0 || wb_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: rsp_valid=%b wb_valid=%b, expected 0 0", rsp_valid, wb_valid);
        end
        for (int a = 0; a < 4; a++) lookup(a, 1'b0, 0, "R1");

        // R2, R3, R4
        for (int a = 16; a < 19; a++) push(a, 1, 1'b1, '0);
        for (int a = 16; a < 19; a++) lookup(a, 1'b1, 1, "R2");
        lookup(16, 1'b0, 0, "R3");
        lookup(18, 1'b0, 0, "R3");
        lookup(99, 1'b0, 0, "R4");

        // R5: 12 distinct inserts, only the last 8 survive
        for (int k = 0; k < 12; k++) push(256 + k, 2, 1'b1, '0);
        for (int k = 0; k < 12; k++) lookup(256 + k, (k >= 12 - ENTRIES), 2, "R5");

        // R6: fill, re-store one address, then one more insert evicts only the oldest
        for (int k = 0; k < 8; k++) push(512 + k, 3, 1'b1, '0);
        push(514, 5, 1'b1, '0);
        push(520, 3, 1'b1, '0);
        lookup(512, 1'b0, 0, "R6");
        lookup(514, 1'b1, 5, "R6");
        lookup(513, 1'b1, 3, "R6");
        for (int k = 3; k < 9; k++) lookup(512 + k, 1'b1, 3, "R6");

        // R7: every non-zero dirty mask, read-only tagged, never stored
        for (int m = 1; m < (1 << SECTORS); m++) begin
            push(768 + m, m, 1'b1, SECTORS'(m));
            chk_wb(1'b1, 768 + m, m, SECTORS'(m), "R7");
            lookup(768 + m, 1'b0, 0, "R7");
        end

        // R8: clean victims of either tag produce no writeback
        push(800, 4, 1'b0, '0);
        chk_wb(1'b0, 0, 0, '0, "R8");
        lookup(800, 1'b0, 0, "R8");
        push(801, 4, 1'b1, '0);
        chk_wb(1'b0, 0, 0, '0, "R8");

        // R9: dirty eviction of a held address removes the stale copy
        push(830, 6, 1'b1, '0);
        push(830, 7, 1'b0, 4'b1000);
        chk_wb(1'b1, 830, 7, 4'b1000, "R9");
        lookup(830, 1'b0, 0, "R9");
        lookup(801, 1'b1, 4, "R9");

        // R10: lookup and insert of one address in the same cycle
        vic_valid = 1'b1; vic_addr = ADDR_W'(900); vic_data = pat(900, 8);
        vic_ro = 1'b1; vic_dirty = '0;
        lk_valid = 1'b1; lk_addr = ADDR_W'(900);
        @(negedge clk);
        vic_valid = 1'b0; vic_ro = 1'b0; lk_valid = 1'b0;
        checks++;
        if (rsp_valid !== 1'b1 || rsp_hit !== 1'b0) begin
            fails++;
            $display("FAIL R10: valid=%b hit=%b, expected 1 0", rsp_valid, rsp_hit);
        end
        lookup(900, 1'b1, 8, "R10");

        summary();
        $finish;
    end

endmodule